// File: doc/BRIEF.md
# Receive Header/Payload Line Steering

This block sits on the receive side of a network DMA engine, between the receive byte FIFO and two write paths. One write path leads into the last-level cache, the other leads to main memory. Each packet arrives one byte per beat, with start and end markers. The start beat also carries the byte address of the destination buffer. The block packs the bytes into cache-line-sized write transactions. Each transaction carries a line-aligned address, a full line of data and one byte enable per lane.

In the default split placement, the transaction holding the start of the packet goes to the cache port. That transaction covers the packet from its first byte up to the first line boundary in the destination, or up to the end of the packet if that comes first. Every later transaction goes to the memory port. The protocol headers are therefore in the cache when the driver looks at them, and bulk payload does not fill the cache. A placement input, sampled with the start beat, can instead send the whole packet to the cache or the whole packet to memory.

The destination may start at any byte alignment, so the first and last transactions can be partial lines. A stalled port holds its request and pushes back on the byte stream. A one-cycle done pulse marks the acceptance of each packet's closing transaction.

Top module: `rx_hdr_steer`

## Requirements
- R1: After reset, both write-request valids and the done pulse are low, and the byte input is ready.
- R2: With placement code 0 (split), the first transaction of a packet is issued on the cache port, and every other transaction of that packet is issued on the memory port. The first transaction covers the bytes from the start address up to and including the byte at offset 63 of that line, or fewer bytes if the packet ends sooner.
- R3: With placement code 1, every transaction of the packet is issued on the cache port.
- R4: With placement code 2, every transaction of the packet is issued on the memory port.
- R5: Placement code 3 behaves exactly like code 0.
- R6: Each transaction address has its low 6 bits zero. The k-th transaction of a packet (counting from 0) addresses the line at the start line plus 64*k bytes. Packet byte i, where the start address is A, is placed in byte lane (A+i) mod 64. Lane j occupies data bits [8j+7:8j].
- R7: Exactly the lanes that received packet bytes have their byte-enable bit (bit j for lane j) set. All other data lanes are zero.
- R8: A packet occupies exactly ceil(((A mod 64) + length) / 64) transactions. A packet that ends on the last byte of a line issues no empty extra transaction.
- R9: The placement code and the address are taken only from the start beat. Values presented on those inputs during later beats of the packet have no effect.
- R10: While a request is valid and its port is not ready, the request keeps valid high with address, data and enables unchanged, and the byte input is not ready. No byte is lost, duplicated or reordered.
- R11: The done output is high for one cycle, in the cycle after the packet's final transaction is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte beat valid |
| in_ready | output | 1 | Byte beat accepted when high together with in_valid |
| in_sop | input | 1 | Beat is the first byte of a packet |
| in_eop | input | 1 | Beat is the last byte of a packet |
| in_data | input | 8 | Packet byte |
| in_addr | input | 32 | Destination byte address of the first byte (start beat only) |
| in_mode | input | 2 | Placement code: 0 split, 1 cache only, 2 memory only, 3 split (start beat only) |
| c_valid | output | 1 | Cache-port write request valid |
| c_ready | input | 1 | Cache port accepts the request |
| c_addr | output | 32 | Cache-port line address |
| c_data | output | 512 | Cache-port line data |
| c_be | output | 64 | Cache-port byte enables |
| m_valid | output | 1 | Memory-port write request valid |
| m_ready | input | 1 | Memory port accepts the request |
| m_addr | output | 32 | Memory-port line address |
| m_data | output | 512 | Memory-port line data |
| m_be | output | 64 | Memory-port byte enables |
| done | output | 1 | One-cycle pulse after a packet's last transaction is accepted |

## Verification
The bench targets the split point for unaligned buffers. A design that split after a fixed 64 bytes of packet, rather than at the destination line boundary, would send a cache write across two lines, and the per-lane enable and address checks catch this. A packet that ends exactly on a line boundary is also covered: an off-by-one there yields a stray empty transaction or merges two lines. Start-beat-only sampling is tested by presenting garbage address and mode on later beats, and a design that re-read them would misroute or misaddress blocks. Random port stalls and input gaps expose dropped or repeated bytes, a done pulse that fires on the wrong handshake, and a request that changes while stalled.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  typedef enum logic [1:0] {
    PLACE_SPLIT = 2'd0,
    PLACE_CACHE = 2'd1,
    PLACE_MEM   = 2'd2,
    PLACE_RSVD  = 2'd3
  } place_e;

  // Destination of one line transaction: 1 = cache port, 0 = memory port.
  function automatic logic steer_to_cache(input place_e mode, input logic first_blk);
    case (mode)
      PLACE_CACHE: steer_to_cache = 1'b1;
      PLACE_MEM:   steer_to_cache = 1'b0;
      default:     steer_to_cache = first_blk;
    endcase
  endfunction

endpackage

// File: rtl/rxs_line_pack.sv
module rxs_line_pack #(
  parameter int ADDR_W = 32,
  parameter int LINE_B = 64,
  localparam int OFF_W  = $clog2(LINE_B),
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int DATA_W = LINE_B * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [7:0]        in_data,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [1:0]        in_mode,
  output logic              close_evt,
  output logic [LINE_W-1:0] blk_line,
  output logic [DATA_W-1:0] blk_data,
  output logic [LINE_B-1:0] blk_be,
  output logic              blk_first,
  output logic              blk_last,
  output logic [1:0]        blk_mode
);

  logic [OFF_W-1:0]  off_q,  cur_off;
  logic [LINE_W-1:0] line_q, cur_line;
  logic [DATA_W-1:0] data_q, cur_data, nxt_data;
  logic [LINE_B-1:0] be_q,   cur_be,   nxt_be;
  logic              first_q, cur_first;
  logic [1:0]        mode_q,  cur_mode;
  logic              closing;

  localparam logic [OFF_W-1:0]  OFF_LAST = OFF_W'(LINE_B - 1);
  localparam logic [OFF_W-1:0]  OFF_ONE  = {{(OFF_W-1){1'b0}}, 1'b1};
  localparam logic [LINE_W-1:0] LINE_ONE = {{(LINE_W-1){1'b0}}, 1'b1};

  // A start beat restarts the line position from the buffer address.
  always_comb begin
    cur_off   = in_sop ? in_addr[OFF_W-1:0]      : off_q;
    cur_line  = in_sop ? in_addr[ADDR_W-1:OFF_W] : line_q;
    cur_data  = in_sop ? '0 : data_q;
    cur_be    = in_sop ? '0 : be_q;
    cur_first = in_sop ? 1'b1 : first_q;
    cur_mode  = in_sop ? in_mode : mode_q;
    nxt_data  = cur_data | ({{(DATA_W-8){1'b0}}, in_data} << {cur_off, 3'b000});
    nxt_be    = cur_be   | ({{(LINE_B-1){1'b0}}, 1'b1} << cur_off);
    closing   = (cur_off == OFF_LAST) || in_eop;
  end

  assign close_evt = take && closing;
  assign blk_line  = cur_line;
  assign blk_data  = nxt_data;
  assign blk_be    = nxt_be;
  assign blk_first = cur_first;
  assign blk_last  = in_eop;
  assign blk_mode  = cur_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q   <= '0;
      line_q  <= '0;
      data_q  <= '0;
      be_q    <= '0;
      first_q <= 1'b0;
      mode_q  <= '0;
    end else if (take) begin
      mode_q <= cur_mode;
      if (closing) begin
        off_q   <= '0;
        line_q  <= cur_line + LINE_ONE;
        data_q  <= '0;
        be_q    <= '0;
        first_q <= 1'b0;
      end else begin
        off_q   <= cur_off + OFF_ONE;
        line_q  <= cur_line;
        data_q  <= nxt_data;
        be_q    <= nxt_be;
        first_q <= cur_first;
      end
    end
  end

  // R8: a block that closes before the end of the packet must be full up to its top lane.
  assert_close_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (close_evt && !in_eop) |-> blk_be[LINE_B-1]);

endmodule

// File: rtl/rxs_out_slot.sv
module rxs_out_slot
  import rxs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_B = 64,
  localparam int OFF_W  = $clog2(LINE_B),
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int DATA_W = LINE_B * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LINE_W-1:0] blk_line,
  input  logic [DATA_W-1:0] blk_data,
  input  logic [LINE_B-1:0] blk_be,
  input  logic              blk_first,
  input  logic              blk_last,
  input  logic [1:0]        blk_mode,
  output logic              slot_free,
  output logic              c_valid,
  input  logic              c_ready,
  output logic [ADDR_W-1:0] c_addr,
  output logic [DATA_W-1:0] c_data,
  output logic [LINE_B-1:0] c_be,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [ADDR_W-1:0] m_addr,
  output logic [DATA_W-1:0] m_data,
  output logic [LINE_B-1:0] m_be,
  output logic              done
);

  logic              vld_q, to_cache_q, last_q, done_q;
  logic [LINE_W-1:0] line_q;
  logic [DATA_W-1:0] data_q;
  logic [LINE_B-1:0] be_q;
  logic              accept;

  assign c_valid   = vld_q && to_cache_q;
  assign m_valid   = vld_q && !to_cache_q;
  assign accept    = (c_valid && c_ready) || (m_valid && m_ready);
  assign slot_free = !vld_q || accept;

  assign c_addr = {line_q, {OFF_W{1'b0}}};
  assign m_addr = {line_q, {OFF_W{1'b0}}};
  assign c_data = data_q;
  assign m_data = data_q;
  assign c_be   = be_q;
  assign m_be   = be_q;
  assign done   = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q      <= 1'b0;
      to_cache_q <= 1'b0;
      last_q     <= 1'b0;
      line_q     <= '0;
      data_q     <= '0;
      be_q       <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= accept && last_q;
      if (load) begin
        vld_q      <= 1'b1;
        to_cache_q <= steer_to_cache(place_e'(blk_mode), blk_first);
        last_q     <= blk_last;
        line_q     <= blk_line;
        data_q     <= blk_data;
        be_q       <= blk_be;
      end else if (accept) begin
        vld_q <= 1'b0;
      end
    end
  end

  // R10: a stalled request keeps its contents.
  assert_hold_cache_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (c_valid && !c_ready) |=> (c_valid && $stable(c_addr) && $stable(c_data) && $stable(c_be)));
  assert_hold_mem_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_data) && $stable(m_be)));
  // R7: every issued transaction writes at least one lane.
  assert_be_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (c_valid || m_valid) |-> ($countones(be_q) != 0));
  // R11: done follows an accepted handshake.
  assert_done_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(c_valid || m_valid));

endmodule

// File: rtl/rx_hdr_steer.sv
module rx_hdr_steer #(
  parameter int ADDR_W = 32,
  parameter int LINE_B = 64,
  localparam int OFF_W  = $clog2(LINE_B),
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int DATA_W = LINE_B * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [7:0]        in_data,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [1:0]        in_mode,
  output logic              c_valid,
  input  logic              c_ready,
  output logic [ADDR_W-1:0] c_addr,
  output logic [DATA_W-1:0] c_data,
  output logic [LINE_B-1:0] c_be,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [ADDR_W-1:0] m_addr,
  output logic [DATA_W-1:0] m_data,
  output logic [LINE_B-1:0] m_be,
  output logic              done
);

  logic              take, close_evt, slot_free;
  logic [LINE_W-1:0] blk_line;
  logic [DATA_W-1:0] blk_data;
  logic [LINE_B-1:0] blk_be;
  logic              blk_first, blk_last;
  logic [1:0]        blk_mode;

  assign in_ready = slot_free;
  assign take     = in_valid && in_ready;

  rxs_line_pack #(.ADDR_W(ADDR_W), .LINE_B(LINE_B)) u_pack (
    .clk(clk), .rst_n(rst_n), .take(take),
    .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
    .in_addr(in_addr), .in_mode(in_mode),
    .close_evt(close_evt), .blk_line(blk_line), .blk_data(blk_data),
    .blk_be(blk_be), .blk_first(blk_first), .blk_last(blk_last),
    .blk_mode(blk_mode)
  );

  rxs_out_slot #(.ADDR_W(ADDR_W), .LINE_B(LINE_B)) u_slot (
    .clk(clk), .rst_n(rst_n), .load(close_evt),
    .blk_line(blk_line), .blk_data(blk_data), .blk_be(blk_be),
    .blk_first(blk_first), .blk_last(blk_last), .blk_mode(blk_mode),
    .slot_free(slot_free),
    .c_valid(c_valid), .c_ready(c_ready), .c_addr(c_addr), .c_data(c_data), .c_be(c_be),
    .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr), .m_data(m_data), .m_be(m_be),
    .done(done)
  );

  // R10: a blocked request back-pressures the byte stream.
  assert_stall_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((c_valid && !c_ready) || (m_valid && !m_ready)) |-> !in_ready);
  // R2: at most one port is requested at a time.
  assert_one_port_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({c_valid, m_valid}));

endmodule

// File: tb/rx_hdr_steer_bench.sv
`timescale 1ns/1ps
module rx_hdr_steer_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [7:0] in_data = '0;
  logic [31:0] in_addr = '0;
  logic [1:0] in_mode = '0;
  logic in_ready;
  logic c_valid, m_valid, done;
  logic c_ready = 1'b0, m_ready = 1'b0;
  logic [31:0] c_addr, m_addr;
  logic [511:0] c_data, m_data;
  logic [63:0] c_be, m_be;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rx_hdr_steer u_rx_hdr_steer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data), .in_addr(in_addr),
    .in_mode(in_mode),
    .c_valid(c_valid), .c_ready(c_ready), .c_addr(c_addr), .c_data(c_data), .c_be(c_be),
    .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr), .m_data(m_data), .m_be(m_be),
    .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed + i * 7) & 255);
  endfunction

  task automatic drive_pkt(input logic [31:0] addr, input int len, input logic [1:0] mode,
                           input int seed, input bit gaps);
    for (int i = 0; i < len; i++) begin
      bit acc;
      if (gaps && (i % 5 == 2)) begin
        @(negedge clk);
        in_valid = 1'b0;
      end
      acc = 1'b0;
      while (!acc) begin
        @(negedge clk);
        in_valid = 1'b1;
        in_sop   = (i == 0);
        in_eop   = (i == len - 1);
        in_data  = pat(seed, i);
        in_addr  = (i == 0) ? addr : 32'hDEAD_BEE7;   // R9 garbage after start
        in_mode  = (i == 0) ? mode : ~mode;
        #1 acc = in_ready;
        @(posedge clk);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sop = 1'b0;
    in_eop = 1'b0;
  endtask

  task automatic collect_pkt(input logic [31:0] addr, input int len, input logic [1:0] mode,
                             input int seed, input bit stall, input string req);
    int off0 = int'(addr[5:0]);
    int n_exp = (off0 + len + 63) / 64;
    int k = 0;
    while (k < n_exp) begin
      bit r;
      @(negedge clk);
      r = stall ? ((cyc % 3) == 0) : 1'b1;
      c_ready = r;
      m_ready = r;
      if (c_valid || m_valid) begin
        if (!r) begin
          #1 chk(in_ready == 1'b0, "R10", "in_ready while stalled", {511'd0, in_ready}, 512'd0);
        end else begin
          bit exp_c;
          logic [511:0] ed, ad;
          logic [63:0] eb, ab;
          logic [31:0] ea, aa;
          exp_c = (mode == 2'd1) ? 1'b1 : (mode == 2'd2) ? 1'b0 : (k == 0);
          ea = {addr[31:6] + 26'(k), 6'd0};
          ed = '0;
          eb = '0;
          for (int l = 0; l < 64; l++) begin
            int p = k * 64 + l;
            if (p >= off0 && p < off0 + len) begin
              eb[l] = 1'b1;
              ed[l*8 +: 8] = pat(seed, p - off0);
            end
          end
          aa = exp_c ? c_addr : m_addr;
          ad = exp_c ? c_data : m_data;
          ab = exp_c ? c_be : m_be;
          chk(exp_c ? (c_valid && !m_valid) : (m_valid && !c_valid), req,
              $sformatf("port blk%0d {c,m}", k), {510'd0, c_valid, m_valid},
              {510'd0, exp_c, !exp_c});
          chk(aa == ea, "R6", $sformatf("addr blk%0d", k), {480'd0, aa}, {480'd0, ea});
          chk(ab == eb, "R7", $sformatf("be blk%0d", k), {448'd0, ab}, {448'd0, eb});
          chk(ad == ed, "R6", $sformatf("data blk%0d", k), ad, ed);
          k++;
          if (k == n_exp) begin
            @(negedge clk);
            chk(done == 1'b1, "R11", "done after last", {511'd0, done}, 512'd1);
            chk(!c_valid && !m_valid, "R8", "no extra transaction",
                {510'd0, c_valid, m_valid}, 512'd0);
            @(negedge clk);
            chk(done == 1'b0, "R11", "done one cycle", {511'd0, done}, 512'd0);
          end
        end
      end
    end
  endtask

  task automatic run_pkt(input logic [31:0] addr, input int len, input logic [1:0] mode,
                         input int seed, input bit stall, input bit gaps, input string req);
    fork
      drive_pkt(addr, len, mode, seed, gaps);
      collect_pkt(addr, len, mode, seed, stall, req);
    join
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!c_valid && !m_valid, "R1", "valids after reset", {510'd0, c_valid, m_valid}, 512'd0);
    chk(done == 1'b0, "R1", "done after reset", {511'd0, done}, 512'd0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", {511'd0, in_ready}, 512'd1);
  endtask

  task automatic t_split_aligned();   run_pkt(32'h0000_1000, 200, 2'd0, 11, 0, 0, "R2"); endtask
  task automatic t_split_unaligned(); run_pkt(32'h0000_2025, 100, 2'd0, 23, 0, 1, "R2"); endtask
  task automatic t_all_cache();       run_pkt(32'h0000_3011, 150, 2'd1, 37, 0, 0, "R3"); endtask
  task automatic t_all_mem();         run_pkt(32'h0000_4003, 150, 2'd2, 41, 0, 0, "R4"); endtask
  task automatic t_reserved();        run_pkt(32'h0000_503F, 90,  2'd3, 53, 0, 0, "R5"); endtask
  task automatic t_short();           run_pkt(32'h0000_6008, 10,  2'd0, 61, 0, 0, "R8"); endtask
  task automatic t_exact_line();
    run_pkt(32'h0000_7000, 64, 2'd0, 71, 0, 0, "R8");
    run_pkt(32'h0000_7130, 16, 2'd2, 73, 0, 0, "R8");
    run_pkt(32'h0000_7230, 80, 2'd0, 79, 0, 0, "R8");
  endtask
  task automatic t_start_only();      run_pkt(32'h0000_8021, 130, 2'd2, 83, 0, 1, "R9"); endtask
  task automatic t_backpressure();    run_pkt(32'h0000_9007, 300, 2'd0, 89, 1, 0, "R10"); endtask
  task automatic t_mtu();             run_pkt(32'h0001_0003, 1518, 2'd0, 97, 1, 1, "R2"); endtask
  task automatic t_one_byte();        run_pkt(32'h0000_A03F, 1, 2'd1, 101, 0, 0, "R3"); endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    c_ready = 1'b1;
    m_ready = 1'b1;
    t_reset();
    t_split_aligned();
    t_split_unaligned();
    t_all_cache();
    t_all_mem();
    t_reserved();
    t_short();
    t_exact_line();
    t_start_only();
    t_backpressure();
    t_mtu();
    t_one_byte();
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule